// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control and status bank of an eight-channel DMA controller. It stores a controller-wide run bit, a per-channel enable word, and two per-channel interrupt-enable words (one for transfer completion, one for errors). Each of the three per-channel words is written through a masked scheme: in a single write, the byte above the data byte selects which data bits take effect. Software can therefore start one channel, or unmask one interrupt, without first reading the word back.

The channel engines report back through three pulse inputs. A done pulse drops that channel's enable bit. A completion pulse or an error pulse sets a sticky raw status bit. Software clears raw status by writing ones to one of two clear-only locations. The bank gives the masked status (raw status ANDed with the interrupt enable) and a single interrupt line that is high while any masked bit is set. The data-movement engines are outside this block. They receive a per-channel run vector, which is the channel enable gated by the controller-wide run bit.

The register port is a plain single-cycle write strobe with a word address. Read data is combinational from the address. A write is visible on read-back and on the outputs in the cycle after the clock edge that takes it.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every stored bit is 0, so every readable location returns 0, `ch_run` is 0 and `irq` is 0.
- R2: Bit 0 of address 0 is the controller run bit, written directly. `ch_run[i]` equals channel-enable bit i ANDed with the run bit.
- R3: A write to address 1 (channel enable) updates bit i (i = 0..7) to `reg_wdata[i]` only when `reg_wdata[8+i]` is 1. Read-back shows the stored value in bits 7:0 and zeros in all upper bits, including the write-enable byte.
- R4: Address 2 (completion interrupt enable) and address 3 (error interrupt enable) use the same masked-write and read-back scheme as R3.
- R5: A pulse on `ch_done[i]` clears channel-enable bit i at the next edge. If a masked write to address 1 with bit 8+i set is taken at the same edge, the written value of bit i wins.
- R6: A pulse on `tfr_set[i]` or `err_set[i]` sets bit i of the completion raw status (read at address 4) or of the error raw status (read at address 5). The bit stays set until it is cleared.
- R7: Writing a 1 to bit i of address 8 clears completion raw bit i, and writing a 1 to bit i of address 9 clears error raw bit i. Zero bits have no effect, and both addresses read as 0.
- R8: When a hardware set and a software clear hit the same status bit at the same edge, the bit ends up set.
- R9: Address 6 reads the completion raw status ANDed with its interrupt enable. Address 7 reads the error raw status ANDed with its interrupt enable.
- R10: `irq` is 1 exactly when any bit read at address 6 or address 7 is 1.
- R11: Writes to the read-only addresses 4 to 7 and to the unmapped addresses 10 to 15 change nothing. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_addr | input | 4 | Word address for both read and write |
| reg_wdata | input | 32 | Write data; bits 15:8 are the write-enable byte for masked words |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ch_done | input | 8 | Per-channel completion pulse that clears the channel enable |
| tfr_set | input | 8 | Per-channel pulse that sets completion raw status |
| err_set | input | 8 | Per-channel pulse that sets error raw status |
| ch_run | output | 8 | Channel enable gated by the controller run bit |
| irq | output | 1 | OR of all masked status bits |

## Verification
The masked write is driven through a sequence of patterns, each checked against a value computed in the bench:
- all enables set, which overwrites the whole word;
- a single enable with data 0, which clears exactly one bit;
- data ones with no enables, which must change nothing;
- split-nibble enables, which show that enabled and disabled halves are handled independently.

Same-edge collisions are driven on purpose: a done pulse against a masked write to the same channel, a done pulse against a write to a different channel, and a status set against a clear of the same bit. These show whether the priority is right rather than just whether a path exists. Masked status and `irq` are checked with raw bits present both inside and outside the interrupt-enable mask, so that a missing AND stage is exposed.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int unsigned CH_COUNT   = 8;
    localparam int unsigned ADDR_BITS  = 4;
    localparam int unsigned WORD_BITS  = 32;

    // word addresses of the bank
    localparam int unsigned A_RUN      = 0;
    localparam int unsigned A_CHEN     = 1;
    localparam int unsigned A_TFR_IE   = 2;
    localparam int unsigned A_ERR_IE   = 3;
    localparam int unsigned A_TFR_RAW  = 4;
    localparam int unsigned A_ERR_RAW  = 5;
    localparam int unsigned A_TFR_MSK  = 6;
    localparam int unsigned A_ERR_MSK  = 7;
    localparam int unsigned A_TFR_CLR  = 8;
    localparam int unsigned A_ERR_CLR  = 9;
    localparam int unsigned REG_COUNT  = 10;

    // index of each masked-write word in the merge array
    localparam int unsigned M_CHEN     = 0;
    localparam int unsigned M_TFR_IE   = 1;
    localparam int unsigned M_ERR_IE   = 2;
    localparam int unsigned MASKED_CNT = 3;

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode #(
    parameter int unsigned AW   = 4,
    parameter int unsigned NREG = 10
) (
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] wr_hit,
    output logic [NREG-1:0] rd_sel
);

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        assign rd_sel[k] = (addr == AW'(k));
        assign wr_hit[k] = wr && rd_sel[k];
    end

endmodule

// File: rtl/dma_ctl_mask_merge.sv
module dma_ctl_mask_merge #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wen,
    input  logic [W-1:0] val,
    output logic [W-1:0] nxt
);

    assign nxt = (cur & ~wen) | (val & wen);

endmodule

// File: rtl/dma_ctl_rdmux.sv
module dma_ctl_rdmux #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 10
) (
    input  logic [NREG-1:0]         sel,
    input  logic [NREG-1:0][DW-1:0] words,
    output logic [DW-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (sel[k]) rdata = rdata | words[k];
        end
    end

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned AW  = ADDR_BITS,
    parameter int unsigned DW  = WORD_BITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] ch_done,
    input  logic [NCH-1:0] tfr_set,
    input  logic [NCH-1:0] err_set,
    output logic [NCH-1:0] ch_run,
    output logic           irq
);

    localparam int unsigned NREG   = REG_COUNT;
    localparam int unsigned WE_LSB = NCH;
    localparam int unsigned WE_MSB = 2 * NCH - 1;

    typedef struct packed {
        logic           run;
        logic [NCH-1:0] ch_en;
        logic [NCH-1:0] tfr_ie;
        logic [NCH-1:0] err_ie;
        logic [NCH-1:0] tfr_raw;
        logic [NCH-1:0] err_raw;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]         wr_hit;
    logic [NREG-1:0]         rd_sel;
    logic [NREG-1:0][DW-1:0] rd_words;
    logic [NCH-1:0]          wen_bits;
    logic [NCH-1:0]          val_bits;
    logic [NCH-1:0]          merge_cur [MASKED_CNT];
    logic [NCH-1:0]          merge_nxt [MASKED_CNT];
    logic [NCH-1:0]          tfr_clr, err_clr;
    logic [NCH-1:0]          tfr_msk, err_msk;
    logic [NCH-1:0]          ch_en_q, tfr_raw_q, err_raw_q;
    logic                    unused_wdata_hi;

    assign wen_bits        = reg_wdata[WE_MSB:WE_LSB];
    assign val_bits        = reg_wdata[NCH-1:0];
    assign unused_wdata_hi = ^reg_wdata[DW-1:WE_MSB+1];

    dma_ctl_decode #(.AW(AW), .NREG(NREG)) u_decode (
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wr_hit (wr_hit),
        .rd_sel (rd_sel)
    );

    // a done pulse is applied before the masked write, so the write wins
    assign merge_cur[M_CHEN]   = st_q.ch_en & ~ch_done;
    assign merge_cur[M_TFR_IE] = st_q.tfr_ie;
    assign merge_cur[M_ERR_IE] = st_q.err_ie;

    for (genvar g = 0; g < MASKED_CNT; g++) begin : g_merge
        dma_ctl_mask_merge #(.W(NCH)) u_merge (
            .cur (merge_cur[g]),
            .wen (wen_bits),
            .val (val_bits),
            .nxt (merge_nxt[g])
        );
    end

    assign tfr_clr = wr_hit[A_TFR_CLR] ? val_bits : '0;
    assign err_clr = wr_hit[A_ERR_CLR] ? val_bits : '0;

    always_comb begin
        st_d = st_q;
        if (wr_hit[A_RUN]) st_d.run = reg_wdata[0];
        st_d.ch_en   = wr_hit[A_CHEN]   ? merge_nxt[M_CHEN]   : merge_cur[M_CHEN];
        st_d.tfr_ie  = wr_hit[A_TFR_IE] ? merge_nxt[M_TFR_IE] : merge_cur[M_TFR_IE];
        st_d.err_ie  = wr_hit[A_ERR_IE] ? merge_nxt[M_ERR_IE] : merge_cur[M_ERR_IE];
        // set is ORed in after the clear: set wins
        st_d.tfr_raw = (st_q.tfr_raw & ~tfr_clr) | tfr_set;
        st_d.err_raw = (st_q.err_raw & ~err_clr) | err_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tfr_msk = st_q.tfr_raw & st_q.tfr_ie;
    assign err_msk = st_q.err_raw & st_q.err_ie;

    always_comb begin
        rd_words             = '0;
        rd_words[A_RUN]      = DW'(st_q.run);
        rd_words[A_CHEN]     = DW'(st_q.ch_en);
        rd_words[A_TFR_IE]   = DW'(st_q.tfr_ie);
        rd_words[A_ERR_IE]   = DW'(st_q.err_ie);
        rd_words[A_TFR_RAW]  = DW'(st_q.tfr_raw);
        rd_words[A_ERR_RAW]  = DW'(st_q.err_raw);
        rd_words[A_TFR_MSK]  = DW'(tfr_msk);
        rd_words[A_ERR_MSK]  = DW'(err_msk);
    end

    dma_ctl_rdmux #(.DW(DW), .NREG(NREG)) u_rdmux (
        .sel   (rd_sel),
        .words (rd_words),
        .rdata (reg_rdata)
    );

    assign ch_en_q   = st_q.ch_en;
    assign tfr_raw_q = st_q.tfr_raw;
    assign err_raw_q = st_q.err_raw;
    assign ch_run    = st_q.ch_en & {NCH{st_q.run}};
    assign irq       = |{tfr_msk, err_msk};

endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
    import dma_ctl_pkg::*;
#(
    parameter int unsigned NCH = CH_COUNT,
    parameter int unsigned AW  = ADDR_BITS,
    parameter int unsigned DW  = WORD_BITS
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_wr,
    input logic [AW-1:0]  reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] tfr_set,
    input logic [NCH-1:0] err_set,
    input logic [NCH-1:0] ch_run,
    input logic           irq,
    input logic [NCH-1:0] ch_en_q,
    input logic [NCH-1:0] tfr_raw_q,
    input logic [NCH-1:0] err_raw_q
);

    logic chen_wr, tclr_wr;
    assign chen_wr = reg_wr && (reg_addr == AW'(A_CHEN));
    assign tclr_wr = reg_wr && (reg_addr == AW'(A_TFR_CLR));

    // R8
    tfr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tfr_set) |=> ((tfr_raw_q & $past(tfr_set)) == $past(tfr_set)));

    // R6
    err_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> ((err_raw_q & $past(err_set)) == $past(err_set)));

    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_done) && !chen_wr) |=> ((ch_en_q & $past(ch_done)) == '0));

    // R3
    no_enable_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chen_wr && (reg_wdata[2*NCH-1:NCH] == '0)) |=> ((ch_en_q & ~$past(ch_en_q)) == '0));

    // R7
    raw_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tfr_set == '0) && !tclr_wr) |=> $stable(tfr_raw_q));

    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tfr_raw_q == '0) && (err_raw_q == '0)) |-> !irq);

    // R2
    run_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en_q == '0) |-> (ch_run == '0));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.NCH(NCH), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/dma_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module dma_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ch_done = '0;
    logic [7:0]  tfr_set = '0;
    logic [7:0]  err_set = '0;
    logic [7:0]  ch_run;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dma_ctl_regs dut_i (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .ch_done, .tfr_set, .err_set, .ch_run, .irq
    );

    // {write data [15:0], expected channel enable [7:0]}, applied in order
    localparam logic [23:0] VEC [7] = '{
        24'hFFA5_A5, 24'h0100_A4, 24'h00FF_A4, 24'hF05A_54,
        24'h0F0F_5F, 24'h8080_DF, 24'hFF00_00
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [7:0] dn, input logic [7:0] ts, input logic [7:0] es);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        ch_done = dn; tfr_set = ts; err_set = es;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; ch_done = '0; tfr_set = '0; err_set = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1 reset read");
        chk({24'h0, ch_run}, 32'h0, "R1 ch_run");
        chk({31'h0, irq}, 32'h0, "R1 irq");

        // R2 run bit gates channels
        wr(4'd1, 32'h0000_0303);
        chk({24'h0, ch_run}, 32'h0, "R2 run off");
        rd(4'd1, 32'h3, "R2 enable stored");
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, 32'h1, "R2 run readback");
        chk({24'h0, ch_run}, 32'h3, "R2 run on");

        // R3 masked-write vectors, upper data bits set to prove they read 0
        for (int i = 0; i < 7; i++) begin
            wr(4'd1, {16'hABCD, VEC[i][23:8]});
            rd(4'd1, {24'h0, VEC[i][7:0]}, "R3 masked chen");
            chk({24'h0, ch_run}, {24'h0, VEC[i][7:0]}, "R3 ch_run");
        end

        // R4 interrupt enables
        wr(4'd2, 32'h0000_0F05);
        rd(4'd2, 32'h05, "R4 tfr ie");
        wr(4'd3, 32'h0000_FF80);
        rd(4'd3, 32'h80, "R4 err ie");
        wr(4'd2, 32'h0000_0202);
        rd(4'd2, 32'h07, "R4 tfr ie merge");
        rd(4'd3, 32'h80, "R4 err ie untouched");

        // R5 done clears; same-edge write wins
        wr(4'd1, 32'h0000_0303);
        cyc(1'b0, 4'd0, 32'h0, 8'h01, 8'h00, 8'h00);
        rd(4'd1, 32'h02, "R5 done clears");
        chk({24'h0, ch_run}, 32'h02, "R5 ch_run after done");
        cyc(1'b1, 4'd1, 32'h0000_0202, 8'h02, 8'h00, 8'h00);
        rd(4'd1, 32'h02, "R5 write beats done");
        cyc(1'b1, 4'd1, 32'h0000_0404, 8'h02, 8'h00, 8'h00);
        rd(4'd1, 32'h04, "R5 done and other write");

        // R6 sticky raw status
        cyc(1'b0, 4'd0, 32'h0, 8'h00, 8'h11, 8'h80);
        repeat (3) @(posedge clk);
        rd(4'd4, 32'h11, "R6 tfr raw");
        rd(4'd5, 32'h80, "R6 err raw");

        // R9 masked status, R10 irq
        rd(4'd6, 32'h01, "R9 tfr masked");
        rd(4'd7, 32'h80, "R9 err masked");
        chk({31'h0, irq}, 32'h1, "R10 irq set");

        // R7 clears
        wr(4'd9, 32'h0000_0080);
        rd(4'd5, 32'h00, "R7 err cleared");
        chk({31'h0, irq}, 32'h1, "R10 irq still from tfr");
        wr(4'd8, 32'h0000_0000);
        rd(4'd4, 32'h11, "R7 zero clear no effect");
        wr(4'd8, 32'h0000_0001);
        rd(4'd4, 32'h10, "R7 tfr bit cleared");
        rd(4'd6, 32'h00, "R9 masked outside ie");
        chk({31'h0, irq}, 32'h0, "R10 irq low with unmasked raw");
        rd(4'd8, 32'h0, "R7 clr reads zero");
        rd(4'd9, 32'h0, "R7 clr reads zero");

        // R8 set beats clear
        cyc(1'b1, 4'd8, 32'h0000_0030, 8'h00, 8'h20, 8'h00);
        rd(4'd4, 32'h20, "R8 set wins");

        // R11 read-only and unmapped addresses
        wr(4'd4, 32'h0000_FFFF);
        rd(4'd4, 32'h20, "R11 raw read-only");
        wr(4'd6, 32'h0000_FFFF);
        rd(4'd2, 32'h07, "R11 masked addr write ignored");
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, 32'h0, "R11 unmapped reads zero");
        rd(4'd1, 32'h04, "R11 chen untouched");
        rd(4'd0, 32'h01, "R11 run untouched");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule